// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block sits in the front end of a floating-point pipeline. It takes one 32-bit instruction word at a time and decides three things. First, whether the word is a floating-point operate of the arithmetic group (group 1), of the compare group (group 2), or neither. Second, which operation it names. Third, for each of its three operand slots (first source, second source, destination), how wide the operand is and whether it holds a packed floating value or a raw 32-bit integer word.

The block also pulls out the three 5-bit register indices. It checks each index against the width of its operand. An index that does not fit the width, or a compare whose destination field is not zero, is flagged as an illegal register and comes with trap type 6.

The block does no arithmetic. Results are registered: one cycle after a word is strobed in, the decode appears together with a one-cycle valid pulse. The decode then stays on the outputs until the next strobe.

Top module: `fpdec_top`

## Requirements
- R1: A word is group 1 when `(word & 32'hC1F80000) == 32'h81A00000` and group 2 when the masked value is `32'h81A80000`. A word in neither group, or whose selector is not listed for its own group in R3 to R6, is reported as unrecognised. In that case the operation code is 0 (none) and all three sizes are 0.
- R2: The 9-bit selector is word[13:5]. The first source index is word[18:14], the second source index is word[4:0] and the destination index is word[29:25]. The three indices are reported unchanged on every decode.
- R3: Sizes are encoded 0 none, 1 single, 2 double, 3 quad. Operation codes are 1 add, 2 subtract, 3 multiply, 4 divide, 5 square root, 6 move, 7 negate, 8 absolute, 9 int-to-float, 10 float-to-int, 11 float-to-float, 12 widening multiply, 13 compare, 14 compare-signalling. In group 1:
  - add is selectors 0x041/0x042/0x043 for single/double/quad;
  - subtract is 0x045/0x046/0x047;
  - multiply is 0x049/0x04A/0x04B;
  - divide is 0x04D/0x04E/0x04F.
  All three operands take that size and none is raw.
- R4: Group 1 square root is 0x029/0x02A/0x02B, with the first source unused. Widening multiply is 0x069 (single sources, double result) and 0x06E (double sources, quad result).
  - Int-to-float is 0x0C4/0x0C8/0x0CC, with a raw single second source and a single/double/quad destination.
  - Float-to-int is 0x0D1/0x0D2/0x0D3, with a single/double/quad second source and a raw single destination.
  - Float-to-float, written as second source then destination: 0x0C6 double to single, 0x0C7 quad to single, 0x0C9 single to double, 0x0CB quad to double, 0x0CD single to quad, 0x0CE double to quad.
- R5: Group 1 selectors 0x001, 0x005 and 0x009 decode as move, negate and absolute. For these the second source and the destination are raw singles and the first source is unused.
- R6: Group 2 selectors 0x051/0x052/0x053 decode as compare, and 0x055/0x056/0x057 as compare-signalling, each for single/double/quad. Both sources take that size and the destination size is none.
- R7: A double operand whose index has bit 0 set makes the decode illegal-register, with trap type 6.
- R8: A quad operand whose index has either of bits 1:0 set makes the decode illegal-register, with trap type 6.
- R9: A compare or compare-signalling whose destination index is nonzero is illegal-register, with trap type 6.
- R10: An operand slot the operation does not use reports size none, and its index is never checked for alignment.
- R11: Decode outputs are registered. `out_valid` is high exactly in the cycle after an `in_valid` strobe. All decode outputs keep their values until the next strobe. After reset `out_valid` and all status flags are 0.
- R12: In every valid cycle exactly one of recognised, illegal-register and unrecognised is set. The trap type is 6 when illegal-register is set and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: decode in_word this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | One-cycle pulse when a decode is ready |
| out_recog | output | 1 | Legal, recognised operation |
| out_badreg | output | 1 | Recognised but register index illegal |
| out_unknown | output | 1 | Not a recognised floating-point operate |
| out_op | output | 4 | Operation code (R3) |
| out_s1_size | output | 2 | First source size |
| out_s2_size | output | 2 | Second source size |
| out_d_size | output | 2 | Destination size |
| out_s2_raw | output | 1 | Second source is a raw integer word |
| out_d_raw | output | 1 | Destination is a raw integer word |
| out_s1_idx | output | 5 | First source index |
| out_s2_idx | output | 5 | Second source index |
| out_d_idx | output | 5 | Destination index |
| out_trap | output | 3 | Trap type, 6 on illegal register |

## Verification
The bench aims at the following corner cases, and each one catches a specific mistake.

- **Group mask.** A selector placed in the wrong group (an add selector with the group-2 pattern, a compare selector with the group-1 pattern) must come out as unrecognised. A design that decodes selectors without checking the group mask would call these recognised.
- **Alignment rules.** Odd double indices and quad indices with bit 1 set are tried in each operand slot. This catches a mixed-up slot, or a quad check that tests only bit 0.
- **Unused slots.** Misaligned values are placed in slots the operation ignores. A design that checks every slot would wrongly report illegal-register here.
- **Compare destination.** A compare with a nonzero destination field is tried. A design that skips this check would call it recognised.
- **Hold behaviour.** A design that does not hold its outputs would show a stale valid pulse, or lose its fields, in the idle cycle after a decode.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_SGL  = 2'd1,
    SZ_DBL  = 2'd2,
    SZ_QUAD = 2'd3
  } opsz_e;

  typedef enum logic [3:0] {
    FOP_NONE = 4'd0,
    FOP_ADD  = 4'd1,
    FOP_SUB  = 4'd2,
    FOP_MUL  = 4'd3,
    FOP_DIV  = 4'd4,
    FOP_SQRT = 4'd5,
    FOP_MOV  = 4'd6,
    FOP_NEG  = 4'd7,
    FOP_ABS  = 4'd8,
    FOP_ITOF = 4'd9,
    FOP_FTOI = 4'd10,
    FOP_FCVT = 4'd11,
    FOP_WMUL = 4'd12,
    FOP_CMP  = 4'd13,
    FOP_CMPX = 4'd14
  } fop_e;

  typedef struct packed {
    logic  known;
    fop_e  op;
    opsz_e s1;
    opsz_e s2;
    opsz_e d;
    logic  raw2;
    logic  rawd;
    logic  cc_dst;
  } fdec_s;

  localparam logic [31:0] GRP_MASK = 32'hC1F8_0000;
  localparam logic [31:0] GRP1_PAT = 32'h81A0_0000;
  localparam logic [31:0] GRP2_PAT = 32'h81A8_0000;

endpackage

// File: rtl/fpdec_table.sv
module fpdec_table
  import fpdec_pkg::*;
#(
  parameter int SEL_W = 9
) (
  input  logic             grp1,
  input  logic             grp2,
  input  logic [SEL_W-1:0] sel,
  output fdec_s            info
);

  function automatic fdec_s set_ops(fop_e op, opsz_e s1, opsz_e s2, opsz_e d,
                                    logic raw2, logic rawd, logic cc);
    fdec_s r;
    r.known  = 1'b1;
    r.op     = op;
    r.s1     = s1;
    r.s2     = s2;
    r.d      = d;
    r.raw2   = raw2;
    r.rawd   = rawd;
    r.cc_dst = cc;
    return r;
  endfunction

  function automatic fdec_s lookup(logic g1, logic g2, logic [SEL_W-1:0] s);
    fdec_s r;
    opsz_e lo;
    r  = '0;
    lo = opsz_e'(s[1:0]);
    if (g2) begin
      if (s[8:3] == 6'h0A && s[1:0] != 2'd0)
        r = set_ops(s[2] ? FOP_CMPX : FOP_CMP, lo, lo, SZ_NONE, 1'b0, 1'b0, 1'b1);
    end else if (g1) begin
      if (s[8:4] == 5'h04 && s[1:0] != 2'd0) begin
        case (s[3:2])
          2'd0:    r = set_ops(FOP_ADD, lo, lo, lo, 1'b0, 1'b0, 1'b0);
          2'd1:    r = set_ops(FOP_SUB, lo, lo, lo, 1'b0, 1'b0, 1'b0);
          2'd2:    r = set_ops(FOP_MUL, lo, lo, lo, 1'b0, 1'b0, 1'b0);
          default: r = set_ops(FOP_DIV, lo, lo, lo, 1'b0, 1'b0, 1'b0);
        endcase
      end else if (s[8:2] == 7'h0A && s[1:0] != 2'd0) begin
        r = set_ops(FOP_SQRT, SZ_NONE, lo, lo, 1'b0, 1'b0, 1'b0);
      end else begin
        case (s)
          9'h001: r = set_ops(FOP_MOV,  SZ_NONE, SZ_SGL, SZ_SGL, 1'b1, 1'b1, 1'b0);
          9'h005: r = set_ops(FOP_NEG,  SZ_NONE, SZ_SGL, SZ_SGL, 1'b1, 1'b1, 1'b0);
          9'h009: r = set_ops(FOP_ABS,  SZ_NONE, SZ_SGL, SZ_SGL, 1'b1, 1'b1, 1'b0);
          9'h069: r = set_ops(FOP_WMUL, SZ_SGL, SZ_SGL, SZ_DBL, 1'b0, 1'b0, 1'b0);
          9'h06E: r = set_ops(FOP_WMUL, SZ_DBL, SZ_DBL, SZ_QUAD, 1'b0, 1'b0, 1'b0);
          9'h0C4, 9'h0C8, 9'h0CC:
                  r = set_ops(FOP_ITOF, SZ_NONE, SZ_SGL, opsz_e'(s[3:2]), 1'b1, 1'b0, 1'b0);
          9'h0D1, 9'h0D2, 9'h0D3:
                  r = set_ops(FOP_FTOI, SZ_NONE, lo, SZ_SGL, 1'b0, 1'b1, 1'b0);
          9'h0C6: r = set_ops(FOP_FCVT, SZ_NONE, SZ_DBL,  SZ_SGL,  1'b0, 1'b0, 1'b0);
          9'h0C7: r = set_ops(FOP_FCVT, SZ_NONE, SZ_QUAD, SZ_SGL,  1'b0, 1'b0, 1'b0);
          9'h0C9: r = set_ops(FOP_FCVT, SZ_NONE, SZ_SGL,  SZ_DBL,  1'b0, 1'b0, 1'b0);
          9'h0CB: r = set_ops(FOP_FCVT, SZ_NONE, SZ_QUAD, SZ_DBL,  1'b0, 1'b0, 1'b0);
          9'h0CD: r = set_ops(FOP_FCVT, SZ_NONE, SZ_SGL,  SZ_QUAD, 1'b0, 1'b0, 1'b0);
          9'h0CE: r = set_ops(FOP_FCVT, SZ_NONE, SZ_DBL,  SZ_QUAD, 1'b0, 1'b0, 1'b0);
          default: r = '0;
        endcase
      end
    end
    return r;
  endfunction

  always_comb info = lookup(grp1, grp2, sel);

endmodule

// File: rtl/fpdec_align.sv
module fpdec_align
  import fpdec_pkg::*;
#(
  parameter int N_OPS = 3,
  parameter int IDX_W = 5
) (
  input  logic [2*N_OPS-1:0]     sz_v,
  input  logic [IDX_W*N_OPS-1:0] idx_v,
  output logic [N_OPS-1:0]       bad_v
);

  function automatic logic misfit(opsz_e sz, logic [IDX_W-1:0] idx);
    case (sz)
      SZ_DBL:  return idx[0];
      SZ_QUAD: return |idx[1:0];
      default: return 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < N_OPS; g++) begin : g_slot
    always_comb bad_v[g] = misfit(opsz_e'(sz_v[2*g +: 2]), idx_v[IDX_W*g +: IDX_W]);
  end

endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int TRAP_W      = 3,
  parameter int TRAP_BADREG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_recog,
  output logic              out_badreg,
  output logic              out_unknown,
  output logic [3:0]        out_op,
  output logic [1:0]        out_s1_size,
  output logic [1:0]        out_s2_size,
  output logic [1:0]        out_d_size,
  output logic              out_s2_raw,
  output logic              out_d_raw,
  output logic [4:0]        out_s1_idx,
  output logic [4:0]        out_s2_idx,
  output logic [4:0]        out_d_idx,
  output logic [TRAP_W-1:0] out_trap
);

  localparam int IDX_W = 5;
  localparam int SEL_W = 9;
  localparam int N_OPS = 3;

  logic             grp1, grp2;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] s1_idx, s2_idx, d_idx;
  fdec_s            info;
  logic [N_OPS-1:0] slot_bad;
  logic             cc_bad, any_bad, dec_bad, dec_ok, dec_unk;

  always_comb begin
    grp1   = (in_word & GRP_MASK) == GRP1_PAT;
    grp2   = (in_word & GRP_MASK) == GRP2_PAT;
    sel    = in_word[13:5];
    s1_idx = in_word[18:14];
    s2_idx = in_word[4:0];
    d_idx  = in_word[29:25];
  end

  fpdec_table #(.SEL_W(SEL_W)) u_table (
    .grp1 (grp1),
    .grp2 (grp2),
    .sel  (sel),
    .info (info)
  );

  fpdec_align #(.N_OPS(N_OPS), .IDX_W(IDX_W)) u_align (
    .sz_v  ({info.d, info.s2, info.s1}),
    .idx_v ({d_idx, s2_idx, s1_idx}),
    .bad_v (slot_bad)
  );

  always_comb begin
    cc_bad  = info.cc_dst && (d_idx != '0);
    any_bad = (|slot_bad) || cc_bad;
    dec_bad = info.known && any_bad;
    dec_ok  = info.known && !any_bad;
    dec_unk = !info.known;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_recog   <= 1'b0;
      out_badreg  <= 1'b0;
      out_unknown <= 1'b0;
      out_op      <= '0;
      out_s1_size <= '0;
      out_s2_size <= '0;
      out_d_size  <= '0;
      out_s2_raw  <= 1'b0;
      out_d_raw   <= 1'b0;
      out_s1_idx  <= '0;
      out_s2_idx  <= '0;
      out_d_idx   <= '0;
      out_trap    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_recog   <= dec_ok;
        out_badreg  <= dec_bad;
        out_unknown <= dec_unk;
        out_op      <= info.op;
        out_s1_size <= info.s1;
        out_s2_size <= info.s2;
        out_d_size  <= info.d;
        out_s2_raw  <= info.raw2;
        out_d_raw   <= info.rawd;
        out_s1_idx  <= s1_idx;
        out_s2_idx  <= s2_idx;
        out_d_idx   <= d_idx;
        out_trap    <= dec_bad ? TRAP_W'(TRAP_BADREG) : '0;
      end
    end
  end

  assert_one_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_recog, out_badreg, out_unknown}) == 1);

  assert_trap_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_badreg ? out_trap == TRAP_W'(TRAP_BADREG) : out_trap == '0));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_op) && $stable(out_d_idx) && $stable(out_recog));

  assert_dbl_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_recog && out_s1_size == SZ_DBL) |-> !out_s1_idx[0]);

  assert_quad_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_recog && out_d_size == SZ_QUAD) |-> out_d_idx[1:0] == 2'd0);

  assert_cc_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_recog && (out_op == FOP_CMP || out_op == FOP_CMPX)) |-> out_d_idx == '0);

  assert_unknown_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unknown) |-> (out_op == FOP_NONE && out_s1_size == SZ_NONE &&
                                    out_s2_size == SZ_NONE && out_d_size == SZ_NONE));

endmodule

// File: tb/fpdec_top_bench.sv
`timescale 1ns/1ps
module fpdec_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_recog, out_badreg, out_unknown;
  logic [3:0]  out_op;
  logic [1:0]  out_s1_size, out_s2_size, out_d_size;
  logic        out_s2_raw, out_d_raw;
  logic [4:0]  out_s1_idx, out_s2_idx, out_d_idx;
  logic [2:0]  out_trap;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  fpdec_top u_fpdec_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_recog(out_recog), .out_badreg(out_badreg),
    .out_unknown(out_unknown), .out_op(out_op), .out_s1_size(out_s1_size),
    .out_s2_size(out_s2_size), .out_d_size(out_d_size), .out_s2_raw(out_s2_raw),
    .out_d_raw(out_d_raw), .out_s1_idx(out_s1_idx), .out_s2_idx(out_s2_idx),
    .out_d_idx(out_d_idx), .out_trap(out_trap)
  );

  localparam logic [2:0] ST_OK  = 3'b100;
  localparam logic [2:0] ST_BAD = 3'b010;
  localparam logic [2:0] ST_UNK = 3'b001;

  function automatic logic [31:0] mk(bit g2, logic [8:0] sel, logic [4:0] rd,
                                     logic [4:0] rs1, logic [4:0] rs2);
    return {2'b10, rd, (g2 ? 6'h35 : 6'h34), rs1, sel, rs2};
  endfunction

  task automatic note(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(logic [31:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic dec(string tag, logic [31:0] w, logic [2:0] st, logic [3:0] op,
                     logic [1:0] s1, logic [1:0] s2, logic [1:0] d,
                     logic r2, logic rd);
    logic [63:0] act, exp;
    strobe(w);
    act = {out_valid, out_recog, out_badreg, out_unknown, out_op, out_s1_size,
           out_s2_size, out_d_size, out_s2_raw, out_d_raw, out_trap};
    exp = {1'b1, st, op, s1, s2, d, r2, rd, (st == ST_BAD) ? 3'd6 : 3'd0};
    note(tag, act, exp);
  endtask

  task automatic t_reset;
    note("R11 reset state", {out_valid, out_recog, out_badreg, out_unknown}, 4'b0);
  endtask

  task automatic t_arith;
    dec("R3 add single",   mk(0, 9'h041, 5'd1, 5'd3, 5'd7),    ST_OK, 4'd1, 2'd1, 2'd1, 2'd1, 0, 0);
    dec("R3 sub double",   mk(0, 9'h046, 5'd2, 5'd4, 5'd6),    ST_OK, 4'd2, 2'd2, 2'd2, 2'd2, 0, 0);
    dec("R3 mul quad",     mk(0, 9'h04B, 5'd4, 5'd8, 5'd12),   ST_OK, 4'd3, 2'd3, 2'd3, 2'd3, 0, 0);
    dec("R3 div single",   mk(0, 9'h04D, 5'd9, 5'd10, 5'd11),  ST_OK, 4'd4, 2'd1, 2'd1, 2'd1, 0, 0);
  endtask

  task automatic t_fields;
    strobe(mk(0, 9'h041, 5'd5, 5'd17, 5'd30));
    note("R2 index fields", {out_s1_idx, out_s2_idx, out_d_idx}, {5'd17, 5'd30, 5'd5});
  endtask

  task automatic t_convert;
    dec("R4 sqrt double",  mk(0, 9'h02A, 5'd2, 5'd0, 5'd4),   ST_OK, 4'd5, 2'd0, 2'd2, 2'd2, 0, 0);
    dec("R4 int to quad",  mk(0, 9'h0CC, 5'd8, 5'd0, 5'd3),   ST_OK, 4'd9, 2'd0, 2'd1, 2'd3, 1, 0);
    dec("R4 quad to int",  mk(0, 9'h0D3, 5'd7, 5'd0, 5'd8),   ST_OK, 4'd10, 2'd0, 2'd3, 2'd1, 0, 1);
    dec("R4 quad to dbl",  mk(0, 9'h0CB, 5'd6, 5'd0, 5'd4),   ST_OK, 4'd11, 2'd0, 2'd3, 2'd2, 0, 0);
    dec("R4 dbl to quad",  mk(0, 9'h0CE, 5'd12, 5'd0, 5'd2),  ST_OK, 4'd11, 2'd0, 2'd2, 2'd3, 0, 0);
    dec("R4 widen dbl",    mk(0, 9'h06E, 5'd16, 5'd2, 5'd6),  ST_OK, 4'd12, 2'd2, 2'd2, 2'd3, 0, 0);
    dec("R4 widen sgl",    mk(0, 9'h069, 5'd2, 5'd1, 5'd3),   ST_OK, 4'd12, 2'd1, 2'd1, 2'd2, 0, 0);
  endtask

  task automatic t_move;
    dec("R5 negate odd idx", mk(0, 9'h005, 5'd31, 5'd0, 5'd7), ST_OK, 4'd7, 2'd0, 2'd1, 2'd1, 1, 1);
    dec("R5 absolute",       mk(0, 9'h009, 5'd3, 5'd0, 5'd5),  ST_OK, 4'd8, 2'd0, 2'd1, 2'd1, 1, 1);
    dec("R5 move",           mk(0, 9'h001, 5'd1, 5'd0, 5'd1),  ST_OK, 4'd6, 2'd0, 2'd1, 2'd1, 1, 1);
  endtask

  task automatic t_compare;
    dec("R6 compare dbl",   mk(1, 9'h052, 5'd0, 5'd2, 5'd10), ST_OK, 4'd13, 2'd2, 2'd2, 2'd0, 0, 0);
    dec("R6 cmp-sig quad",  mk(1, 9'h057, 5'd0, 5'd4, 5'd28), ST_OK, 4'd14, 2'd3, 2'd3, 2'd0, 0, 0);
    dec("R6 cmp-sig single",mk(1, 9'h055, 5'd0, 5'd3, 5'd5),  ST_OK, 4'd14, 2'd1, 2'd1, 2'd0, 0, 0);
  endtask

  task automatic t_align;
    dec("R7 dbl odd src1",  mk(0, 9'h042, 5'd2, 5'd3, 5'd4),  ST_BAD, 4'd1, 2'd2, 2'd2, 2'd2, 0, 0);
    dec("R7 dbl odd dest",  mk(0, 9'h0C9, 5'd5, 5'd0, 5'd1),  ST_BAD, 4'd11, 2'd0, 2'd1, 2'd2, 0, 0);
    dec("R8 quad src2 b1",  mk(0, 9'h043, 5'd4, 5'd8, 5'd2),  ST_BAD, 4'd1, 2'd3, 2'd3, 2'd3, 0, 0);
    dec("R8 quad dest b1",  mk(0, 9'h0CD, 5'd6, 5'd0, 5'd1),  ST_BAD, 4'd11, 2'd0, 2'd1, 2'd3, 0, 0);
    dec("R9 cmp dest nz",   mk(1, 9'h051, 5'd1, 5'd1, 5'd2),  ST_BAD, 4'd13, 2'd1, 2'd1, 2'd0, 0, 0);
  endtask

  task automatic t_unused;
    dec("R10 sqrt odd unused src1", mk(0, 9'h02B, 5'd8, 5'd7, 5'd4), ST_OK, 4'd5, 2'd0, 2'd3, 2'd3, 0, 0);
    dec("R10 ftoi dbl unused src1", mk(0, 9'h0D2, 5'd3, 5'd31, 5'd6), ST_OK, 4'd10, 2'd0, 2'd2, 2'd1, 0, 1);
  endtask

  task automatic t_unknown;
    dec("R1 add sel in group2", mk(1, 9'h041, 5'd0, 5'd0, 5'd0), ST_UNK, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    dec("R1 cmp sel in group1", mk(0, 9'h051, 5'd0, 5'd0, 5'd0), ST_UNK, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    dec("R1 hole selector",     mk(0, 9'h044, 5'd0, 5'd0, 5'd0), ST_UNK, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    dec("R1 zero word",         32'h0,                           ST_UNK, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    dec("R1 bit30 set",         mk(0, 9'h041, 5'd0, 5'd0, 5'd0) | 32'h4000_0000,
                                                                 ST_UNK, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
  endtask

  task automatic t_hold;
    strobe(mk(0, 9'h04A, 5'd10, 5'd12, 5'd14));
    @(negedge clk);
    note("R11 idle cycle holds", {out_valid, out_recog, out_op, out_d_idx},
         {1'b0, 1'b1, 4'd3, 5'd10});
    note("R12 single status held", {out_badreg, out_unknown, out_trap}, 5'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_arith();
    t_fields();
    t_convert();
    t_move();
    t_compare();
    t_align();
    t_unused();
    t_unknown();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule